// File: doc/BRIEF.md
# Latency-Hiding Group Scheduler

This block decides, every clock, which resident group of work items may issue its next instruction on a shared SIMD core. Groups that hit a long-latency operation are parked as stalled, and the core keeps busy by rotating among the others. A completion token returns a stalled group to the runnable set. A done signal retires a group and releases its slot.

Residency is limited in two ways. There is a fixed number of slots. There is also a context pool, counted in allocation units. A launch reserves the size it asks for, and the reservation is returned when the group retires. Small contexts therefore allow many resident groups, and large contexts allow only a few.

Top module: `group_issue_sched`

## Requirements
- R1: After reset every slot is free, `issue_valid_o` is 0, `launch_id_o` is 0 and the whole pool (POOL_SIZE units) is free.
- R2: A launch request with size 0 or a size larger than the free pool space is refused: `launch_ready_o` is 0.
- R3: An accepted launch (`launch_req_i` and `launch_ready_o` in the same cycle) takes the lowest-numbered free slot, which `launch_id_o` shows before the edge, and that slot is runnable from the next cycle on.
- R4: The free pool space drops by the launch size on acceptance and rises by the group's size when it retires. A launch is refused when no slot is free, even if pool space remains. With a pool of 16 units, four groups of size 4 or eight groups of size 1 can be resident.
- R5: While `issue_valid_o` is 1, `issue_id_o` is the first runnable slot after the last issued slot, in increasing order with wrap-around. The issue pointer starts so that slot 0 is examined first.
- R6: `stall_i` with `stall_id_i` naming a runnable slot makes that slot stalled from the next cycle, and it is not issued while stalled.
- R7: `cpl_valid_i` with `cpl_id_i` naming a stalled slot makes it runnable in the next cycle. A token naming a free or runnable slot changes nothing.
- R8: When no slot is runnable, `issue_valid_o` is 0.
- R9: `done_i` with `done_id_i` naming an occupied slot frees it in the next cycle. When several events name the same slot in one cycle, done takes priority over stall, and stall takes priority over completion.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| launch_req_i | input | 1 | Request to make a new group resident |
| launch_size_i | input | SW | Context size requested, in pool units |
| launch_ready_o | output | 1 | Launch would be accepted this cycle |
| launch_id_o | output | IW | Slot a launch accepted this cycle would take |
| stall_i | input | 1 | A group has issued a long-latency operation |
| stall_id_i | input | IW | Slot of the stalling group |
| cpl_valid_i | input | 1 | Completion token present |
| cpl_id_i | input | IW | Slot the completion belongs to |
| done_i | input | 1 | A group has finished |
| done_id_i | input | IW | Slot of the finished group |
| issue_valid_o | output | 1 | A group is selected for issue |
| issue_id_o | output | IW | Selected slot |

## Verification
The hardest situation to reach is several events colliding on one slot in a single cycle, for example a retire and a completion token arriving together for a stalled group. The bench first stalls every resident group, which it confirms by seeing issue go idle. It then retires one group while a completion token names that same group. The outcome is read through the launch port, which shows which slot is lowest free, and through the issue port, which must never pick the retired slot. Round-robin order is checked by first filling the slots with small contexts and then observing the issued IDs wrap through all of them.

// File: rtl/gsched_pkg.sv
package gsched_pkg;
  typedef enum logic [1:0] {
    SLOT_FREE  = 2'd0,
    SLOT_RUN   = 2'd1,
    SLOT_STALL = 2'd2
  } slot_state_e;
endpackage

// File: rtl/ctx_pool.sv
module ctx_pool #(
  parameter int POOL_SIZE = 16,
  parameter int SW        = $clog2(POOL_SIZE + 1)
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          take_en_i,
  input  logic [SW-1:0] take_size_i,
  input  logic [SW-1:0] give_size_i,
  output logic [SW-1:0] free_o
);
  localparam logic [SW-1:0] PoolMax = SW'(POOL_SIZE);

  logic [SW-1:0] free_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) free_q <= PoolMax;
    else         free_q <= free_q - (take_en_i ? take_size_i : '0) + give_size_i;
  end

  assign free_o = free_q;

  assert_pool_bound_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    free_q <= PoolMax);
  assert_no_overdraw_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    take_en_i |-> (take_size_i <= free_q && take_size_i != '0));
endmodule

// File: rtl/slot_table.sv
module slot_table
  import gsched_pkg::*;
#(
  parameter int N  = 8,
  parameter int IW = 3,
  parameter int SW = 5
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          launch_fire_i,
  input  logic [IW-1:0] launch_slot_i,
  input  logic [SW-1:0] launch_size_i,
  input  logic          stall_i,
  input  logic [IW-1:0] stall_id_i,
  input  logic          cpl_valid_i,
  input  logic [IW-1:0] cpl_id_i,
  input  logic          done_i,
  input  logic [IW-1:0] done_id_i,
  output logic [N-1:0]  runnable_o,
  output logic [N-1:0]  free_o,
  output logic [SW-1:0] size_o [N],
  output logic [SW-1:0] ret_size_o
);
  slot_state_e st_q [N];
  logic [SW-1:0] sz_q [N];

  for (genvar i = 0; i < N; i++) begin : g_slot
    logic hit_done, hit_launch, hit_stall, hit_cpl;
    assign hit_done   = done_i && done_id_i == IW'(i) && st_q[i] != SLOT_FREE;
    assign hit_launch = launch_fire_i && launch_slot_i == IW'(i);
    assign hit_stall  = stall_i && stall_id_i == IW'(i) && st_q[i] == SLOT_RUN;
    assign hit_cpl    = cpl_valid_i && cpl_id_i == IW'(i) && st_q[i] == SLOT_STALL;

    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
        st_q[i] <= SLOT_FREE;
        sz_q[i] <= '0;
      end else if (hit_done) begin
        st_q[i] <= SLOT_FREE;
        sz_q[i] <= '0;
      end else if (hit_launch) begin
        st_q[i] <= SLOT_RUN;
        sz_q[i] <= launch_size_i;
      end else if (hit_stall) begin
        st_q[i] <= SLOT_STALL;
      end else if (hit_cpl) begin
        st_q[i] <= SLOT_RUN;
      end
    end

    assign runnable_o[i] = st_q[i] == SLOT_RUN;
    assign free_o[i]     = st_q[i] == SLOT_FREE;
    assign size_o[i]     = sz_q[i];

    assert_launch_runs_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (launch_fire_i && launch_slot_i == IW'(i)) |=> st_q[i] == SLOT_RUN);
    assert_stall_parks_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (stall_i && stall_id_i == IW'(i) && st_q[i] == SLOT_RUN &&
       !(done_i && done_id_i == IW'(i))) |=> st_q[i] == SLOT_STALL);
    assert_cpl_wakes_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (cpl_valid_i && cpl_id_i == IW'(i) && st_q[i] == SLOT_STALL &&
       !(done_i && done_id_i == IW'(i))) |=> st_q[i] == SLOT_RUN);
    assert_done_frees_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (done_i && done_id_i == IW'(i)) |=> st_q[i] == SLOT_FREE);
  end

  assign ret_size_o = (done_i && st_q[done_id_i] != SLOT_FREE) ? sz_q[done_id_i] : '0;
endmodule

// File: rtl/rr_picker.sv
module rr_picker #(
  parameter int N  = 8,
  parameter int IW = 3
) (
  input  logic [N-1:0]  req_i,
  input  logic [IW-1:0] last_i,
  output logic          gnt_valid_o,
  output logic [IW-1:0] gnt_id_o
);
  always_comb begin
    gnt_valid_o = 1'b0;
    gnt_id_o    = '0;
    for (int k = 1; k <= N; k++) begin
      logic [IW-1:0] idx;
      idx = IW'((int'(last_i) + k) % N);
      if (!gnt_valid_o && req_i[idx]) begin
        gnt_valid_o = 1'b1;
        gnt_id_o    = idx;
      end
    end
  end
endmodule

// File: rtl/group_issue_sched.sv
module group_issue_sched #(
  parameter int NUM_SLOTS = 8,
  parameter int POOL_SIZE = 16,
  localparam int IW = (NUM_SLOTS > 1) ? $clog2(NUM_SLOTS) : 1,
  localparam int SW = $clog2(POOL_SIZE + 1)
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          launch_req_i,
  input  logic [SW-1:0] launch_size_i,
  output logic          launch_ready_o,
  output logic [IW-1:0] launch_id_o,
  input  logic          stall_i,
  input  logic [IW-1:0] stall_id_i,
  input  logic          cpl_valid_i,
  input  logic [IW-1:0] cpl_id_i,
  input  logic          done_i,
  input  logic [IW-1:0] done_id_i,
  output logic          issue_valid_o,
  output logic [IW-1:0] issue_id_o
);
  localparam int AW = SW + IW + 1;

  logic [NUM_SLOTS-1:0] runnable, free_slots;
  logic [SW-1:0]        slot_size [NUM_SLOTS];
  logic [SW-1:0]        ret_size, free_space;
  logic                 has_free, launch_fire;
  logic [IW-1:0]        last_q;

  // lowest free slot
  always_comb begin
    has_free    = 1'b0;
    launch_id_o = '0;
    for (int k = NUM_SLOTS - 1; k >= 0; k--) begin
      if (free_slots[k]) begin
        has_free    = 1'b1;
        launch_id_o = IW'(k);
      end
    end
  end

  assign launch_ready_o = has_free && launch_size_i != '0 && launch_size_i <= free_space;
  assign launch_fire    = launch_req_i && launch_ready_o;

  slot_table #(.N(NUM_SLOTS), .IW(IW), .SW(SW)) u_table (
    .clk_i, .rst_ni,
    .launch_fire_i (launch_fire),
    .launch_slot_i (launch_id_o),
    .launch_size_i (launch_size_i),
    .stall_i, .stall_id_i,
    .cpl_valid_i, .cpl_id_i,
    .done_i, .done_id_i,
    .runnable_o (runnable),
    .free_o     (free_slots),
    .size_o     (slot_size),
    .ret_size_o (ret_size)
  );

  ctx_pool #(.POOL_SIZE(POOL_SIZE), .SW(SW)) u_pool (
    .clk_i, .rst_ni,
    .take_en_i   (launch_fire),
    .take_size_i (launch_size_i),
    .give_size_i (ret_size),
    .free_o      (free_space)
  );

  rr_picker #(.N(NUM_SLOTS), .IW(IW)) u_pick (
    .req_i       (runnable),
    .last_i      (last_q),
    .gnt_valid_o (issue_valid_o),
    .gnt_id_o    (issue_id_o)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)            last_q <= IW'(NUM_SLOTS - 1);
    else if (issue_valid_o) last_q <= issue_id_o;
  end

  // pool accounting: free + reserved == pool
  logic [AW-1:0] reserved;
  always_comb begin
    reserved = '0;
    for (int k = 0; k < NUM_SLOTS; k++) reserved = reserved + AW'(slot_size[k]);
  end

  assert_pool_balance_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    reserved + AW'(free_space) == AW'(POOL_SIZE));
  assert_issue_runnable_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    issue_valid_o |-> runnable[issue_id_o]);
  assert_idle_empty_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !issue_valid_o |-> runnable == '0);
  assert_last_tracks_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    issue_valid_o |=> last_q == $past(issue_id_o));
endmodule

// File: tb/group_issue_sched_tb_top.sv
module group_issue_sched_tb_top;
  localparam int N = 8;
  localparam int P = 16;
  localparam int IW = 3;
  localparam int SW = 5;

  logic clk_i = 1'b0, rst_ni = 1'b0;
  logic launch_req_i = 0; logic [SW-1:0] launch_size_i = '0;
  logic launch_ready_o; logic [IW-1:0] launch_id_o;
  logic stall_i = 0; logic [IW-1:0] stall_id_i = '0;
  logic cpl_valid_i = 0; logic [IW-1:0] cpl_id_i = '0;
  logic done_i = 0; logic [IW-1:0] done_id_i = '0;
  logic issue_valid_o; logic [IW-1:0] issue_id_o;

  int checks = 0, fails = 0;

  always #5 clk_i = ~clk_i;

  group_issue_sched #(.NUM_SLOTS(N), .POOL_SIZE(P)) dut_i (.*);

  task automatic chk(input logic ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic tick();
    @(posedge clk_i); #1;
  endtask

  task automatic launch(input int sz, input int exp_id);
    launch_req_i = 1; launch_size_i = SW'(sz); #1;
    chk(launch_ready_o, "R3 launch ready", int'(launch_ready_o), 1);
    chk(launch_id_o == IW'(exp_id), "R3 lowest free slot", int'(launch_id_o), exp_id);
    tick();
    launch_req_i = 0; #1;
  endtask

  task automatic refuse(input int sz, input string tag);
    launch_req_i = 1; launch_size_i = SW'(sz); #1;
    chk(!launch_ready_o, tag, int'(launch_ready_o), 0);
    tick();
    launch_req_i = 0; #1;
  endtask

  task automatic t_reset();
    chk(!issue_valid_o, "R1 idle after reset", int'(issue_valid_o), 0);
    chk(launch_id_o == 0, "R1 slot 0 free", int'(launch_id_o), 0);
    launch_size_i = SW'(P); #1;
    chk(launch_ready_o, "R1 whole pool free", int'(launch_ready_o), 1);
    launch_size_i = SW'(P + 1); #1;
    chk(!launch_ready_o, "R2 oversize refused", int'(launch_ready_o), 0);
    launch_size_i = '0; #1;
    chk(!launch_ready_o, "R2 zero size refused", int'(launch_ready_o), 0);
  endtask

  task automatic t_rr(input int span, input string tag);
    int prev = int'(issue_id_o);
    for (int c = 0; c < 2 * span; c++) begin
      tick();
      chk(issue_valid_o && int'(issue_id_o) == (prev + 1) % span, tag, int'(issue_id_o), (prev + 1) % span);
      prev = int'(issue_id_o);
    end
  endtask

  task automatic t_fill_large();
    for (int i = 0; i < 4; i++) launch(4, i);
    chk(issue_valid_o, "R3 launched group runnable", int'(issue_valid_o), 1);
    refuse(1, "R4 pool exhausted refuses");
    t_rr(4, "R5 round robin over four");
  endtask

  task automatic t_stall_wake();
    int x = int'(issue_id_o);
    bit seen = 0;
    stall_i = 1; stall_id_i = IW'(x); tick(); stall_i = 0;
    for (int c = 0; c < 6; c++) begin
      chk(issue_valid_o && int'(issue_id_o) != x, "R6 stalled not issued", int'(issue_id_o), -1);
      tick();
    end
    cpl_valid_i = 1; cpl_id_i = IW'(5); tick(); cpl_valid_i = 0;
    for (int c = 0; c < 8; c++) begin
      chk(int'(issue_id_o) != 5, "R7 token on free slot ignored", int'(issue_id_o), -1);
      tick();
    end
    cpl_valid_i = 1; cpl_id_i = IW'(x); tick(); cpl_valid_i = 0;
    for (int c = 0; c < 4; c++) begin
      if (int'(issue_id_o) == x) seen = 1;
      tick();
    end
    chk(seen, "R7 completion wakes group", int'(seen), 1);
  endtask

  task automatic t_all_stalled();
    for (int i = 0; i < 4; i++) begin
      stall_i = 1; stall_id_i = IW'(i); tick();
    end
    stall_i = 0;
    for (int c = 0; c < 3; c++) begin
      chk(!issue_valid_o, "R8 idle when none runnable", int'(issue_valid_o), 0);
      tick();
    end
  endtask

  task automatic t_retire();
    refuse(5, "R2 size above free space");
    done_i = 1; done_id_i = IW'(2); tick(); done_i = 0;
    chk(!issue_valid_o, "R9 retired slot not issued", int'(issue_valid_o), 0);
    launch(4, 2);
    chk(issue_valid_o && issue_id_o == 2, "R3 relaunched slot issues", int'(issue_id_o), 2);
  endtask

  task automatic t_collide();
    done_i = 1; done_id_i = IW'(1); cpl_valid_i = 1; cpl_id_i = IW'(1);
    tick();
    done_i = 0; cpl_valid_i = 0;
    launch_size_i = SW'(4); #1;
    chk(launch_ready_o && launch_id_o == 1, "R9 done beats completion", int'(launch_id_o), 1);
    for (int c = 0; c < 4; c++) begin
      chk(issue_valid_o && issue_id_o == 2, "R9 freed slot never issued", int'(issue_id_o), 2);
      tick();
    end
  endtask

  task automatic t_small();
    for (int i = 0; i < 4; i++) begin
      if (i != 1) begin done_i = 1; done_id_i = IW'(i); tick(); end
    end
    done_i = 0; #1;
    chk(!issue_valid_o, "R9 all retired", int'(issue_valid_o), 0);
    for (int i = 0; i < N; i++) launch(1, i);
    refuse(1, "R4 no slot left refuses");
    t_rr(N, "R5 round robin over eight");
  endtask

  initial begin
    repeat (3) @(posedge clk_i);
    #1;
    t_reset();
    rst_ni = 1; tick();
    t_reset();
    t_fill_large();
    t_stall_wake();
    t_all_stalled();
    t_retire();
    t_collide();
    t_small();
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk_i);
    checks++; fails++;
    $display("FAIL watchdog expired actual=1 expected=0");
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule